// File: doc/BRIEF.md
# Debug Address/Data Match Trigger

This block is a single hardware debug trigger of the match-control kind. It keeps a control register and a target register. Both are written through a CSR-style write port that carries a qualifier saying whether the write comes from debug mode. Both are always visible on readback outputs.

On every presented match request, the trigger compares a value against the target. The value is an address, load/store data or an instruction opcode. The comparison uses one of six match modes, and the result is qualified by:
- the operation kind (load, store or execute),
- the privilege level,
- the before/after timing,
- whether the request carries an address or a data value.

A qualified match raises a one-cycle local-hit pulse on the cycle after the request and sets the sticky hit bit in the control register. The surrounding core handles chaining, breakpoint exceptions and debug entry.

The control layout is fixed (XLEN = 32 by default):

| Bits | Field |
|------|-------|
| 0 | load enable |
| 1 | store enable |
| 2 | execute enable |
| 3 | user-mode enable |
| 4 | supervisor-mode enable |
| 5 | reserved, zero |
| 6 | machine-mode enable |
| 10:7 | match mode |
| 11 | chain |
| 17:12 | action |
| 18 | timing |
| 19 | select |
| 20 | hit |
| XLEN-11 to XLEN-6 | maskmax |
| XLEN-5 | dmode |
| top 4 bits | type |

The match request is a plain valid-qualified strobe. The block accepts a request every cycle and applies no back-pressure.

Top module: `dbg_match_trigger`

## Requirements
- R1: After reset the control readback equals CTRL_RST (default: type field = 2, all else 0), the target readback equals TGT_RST (default 0), and hit_o is 0.
- R2: While the stored dmode bit (XLEN-5) is 1, a write with csr_dbg=0 to either register leaves both readbacks unchanged. A write with csr_dbg=0 never changes dmode.
- R3: When a control write leaves dmode at 0, the action field (bits 17:12) reads 0. dmode=0 with a non-zero action is never held.
- R4: Masked mode (match=1) compares only the bits set in a mask derived from the target. With n trailing one bits in the target, the mask is all-ones shifted left by n+1. When n = XLEN-1 the mask is 0, so every value matches.
- R5: Match encodings are 0 equal, 2 unsigned greater-or-equal, 3 unsigned less-than, 4 and 5 as follows; other codes never match.
  - 4: the low half of the value, ANDed with the target's high half, equals the target's low half.
  - 5: the value's high half, ANDed with the target's high half, equals the target's low half.
- R6: For execute requests with select=0 (address), bit 0 of both value and target is ignored.
- R7: A request matches only if the enable for its privilege (m_priv: 0 user, 1 supervisor, 3 machine; 2 never matches) is set in bit 3, 4 or 6.
- R8: Only bits set in CTRL_WMASK / TGT_WMASK are written. By default the reserved bit 5, maskmax and type are read-only.
- R9: A request matches only when the following all hold:
  - its kind is enabled (m_kind: 0 load/bit 0, 1 store/bit 1, 2 execute/bit 2);
  - m_timing equals the timing bit;
  - m_isdata equals the select bit.
- R10: hit_o is 1 in the cycle after a valid matching request, for one cycle. The same edge sets control bit 20, which stays set until written.
- R11: A control write that leaves select=1 clears the load enable unless DATA_MATCH_EN, and clears the execute enable unless OPCODE_MATCH_EN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 control register, 1 target register |
| csr_dbg | input | 1 | Write issued from debug mode |
| csr_wdata | input | XLEN | Write data |
| ctrl_rdata | output | XLEN | Control register readback |
| tgt_rdata | output | XLEN | Target register readback |
| m_valid | input | 1 | Match request present |
| m_kind | input | 2 | 0 load, 1 store, 2 execute |
| m_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| m_timing | input | 1 | 0 before, 1 after |
| m_isdata | input | 1 | 0 value is an address, 1 data or opcode |
| m_value | input | XLEN | Value to compare |
| hit_o | output | 1 | Local-hit pulse |

## Verification
The compare is driven in each mode with a pair of values: one placed exactly on the decision edge and one just past it. For greater-or-equal and less-than, the pair straddles the sign bit, which separates unsigned from signed compares. Masked mode is tried with a short run of trailing ones and with the all-but-top-bit target. The half-mask modes use values that differ only in an ignored or a compared bit. A single matching request is then repeated with one qualifier changed at a time (privilege, kind, timing, select, bit 0 of an instruction address) to show that each qualifier alone can suppress the hit. The dmode rules are tried with writes from both modes against a locked and an unlocked trigger.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int unsigned F_LOAD     = 0;
  localparam int unsigned F_STORE    = 1;
  localparam int unsigned F_EXEC     = 2;
  localparam int unsigned F_UMODE    = 3;
  localparam int unsigned F_SMODE    = 4;
  localparam int unsigned F_MMODE    = 6;
  localparam int unsigned F_MATCH_LO = 7;
  localparam int unsigned F_MATCH_W  = 4;
  localparam int unsigned F_ACT_LO   = 12;
  localparam int unsigned F_ACT_W    = 6;
  localparam int unsigned F_TIMING   = 18;
  localparam int unsigned F_SELECT   = 19;
  localparam int unsigned F_HIT      = 20;

  typedef enum logic [3:0] {
    CMP_EQ      = 4'd0,
    CMP_MASKED  = 4'd1,
    CMP_GE      = 4'd2,
    CMP_LT      = 4'd3,
    CMP_HI_MASK = 4'd4,
    CMP_LO_MASK = 4'd5
  } cmp_mode_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EXEC  = 2'd2,
    OP_NONE  = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } priv_e;

  function automatic int unsigned dmode_pos(int unsigned xlen);
    return xlen - 5;
  endfunction
endpackage

// File: rtl/trig_cmask.sv
module trig_cmask #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] tgt,
  output logic [XLEN-1:0] cmask
);
  int  n;
  logic seen_zero;

  always_comb begin
    n = XLEN;
    seen_zero = 1'b0;
    for (int i = 0; i < XLEN; i++) begin
      if (!seen_zero && !tgt[i]) begin
        n = i;
        seen_zero = 1'b1;
      end
    end
    if (n == XLEN - 1)
      cmask = '0;
    else if (n < XLEN)
      cmask = {XLEN{1'b1}} << (n + 1);
    else
      cmask = {XLEN{1'b1}};
  end
endmodule

// File: rtl/trig_compare.sv
module trig_compare
  import dbg_trig_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [3:0]      mode,
  input  logic [XLEN-1:0] value,
  input  logic [XLEN-1:0] tgt,
  input  logic [XLEN-1:0] cmask,
  output logic            match
);
  localparam int unsigned H = XLEN / 2;

  logic [H-1:0] v_lo, v_hi, t_lo, t_hi;
  assign v_lo = value[H-1:0];
  assign v_hi = value[XLEN-1:H];
  assign t_lo = tgt[H-1:0];
  assign t_hi = tgt[XLEN-1:H];

  always_comb begin
    case (cmp_mode_e'(mode))
      CMP_EQ:      match = (value == tgt);
      CMP_MASKED:  match = ((value & cmask) == (tgt & cmask));
      CMP_GE:      match = (value >= tgt);
      CMP_LT:      match = (value < tgt);
      CMP_HI_MASK: match = ((v_lo & t_hi) == t_lo);
      CMP_LO_MASK: match = ((v_hi & t_hi) == t_lo);
      default:     match = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_regs.sv
module trig_regs
  import dbg_trig_pkg::*;
#(
  parameter int unsigned     XLEN            = 32,
  parameter logic [XLEN-1:0] CTRL_WMASK      = '1,
  parameter logic [XLEN-1:0] TGT_WMASK       = '1,
  parameter logic [XLEN-1:0] CTRL_RST        = '0,
  parameter logic [XLEN-1:0] TGT_RST         = '0,
  parameter bit              DATA_MATCH_EN   = 1'b0,
  parameter bit              OPCODE_MATCH_EN = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic            csr_sel,
  input  logic            csr_dbg,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            hit_set,
  output logic [XLEN-1:0] ctrl_q,
  output logic [XLEN-1:0] tgt_q
);
  localparam int unsigned DM = dmode_pos(XLEN);

  logic [XLEN-1:0] wmask, cw, ctrl_d, tgt_d;
  logic            locked;

  always_comb begin
    wmask = CTRL_WMASK;
    if (!csr_dbg) wmask[DM] = 1'b0;
    cw = (csr_wdata & wmask) | (ctrl_q & ~wmask);
    if (cw[F_SELECT]) begin
      if (!DATA_MATCH_EN)   cw[F_LOAD] = 1'b0;
      if (!OPCODE_MATCH_EN) cw[F_EXEC] = 1'b0;
    end
    if (!cw[DM]) cw[F_ACT_LO +: F_ACT_W] = '0;

    locked = ctrl_q[DM] && !csr_dbg;
    ctrl_d = ctrl_q;
    tgt_d  = tgt_q;
    if (csr_we && !locked) begin
      if (!csr_sel) ctrl_d = cw;
      else          tgt_d  = (csr_wdata & TGT_WMASK) | (tgt_q & ~TGT_WMASK);
    end
    if (hit_set) ctrl_d[F_HIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      tgt_q  <= TGT_RST;
    end else begin
      ctrl_q <= ctrl_d;
      tgt_q  <= tgt_d;
    end
  end
endmodule

// File: rtl/dbg_match_trigger.sv
module dbg_match_trigger
  import dbg_trig_pkg::*;
#(
  parameter int unsigned     XLEN            = 32,
  parameter logic [XLEN-1:0] CTRL_WMASK      = ~(XLEN'(1) << 5)
                                               & ~(XLEN'(6'h3F) << (XLEN - 11))
                                               & ~(XLEN'(4'hF) << (XLEN - 4)),
  parameter logic [XLEN-1:0] TGT_WMASK       = '1,
  parameter logic [XLEN-1:0] CTRL_RST        = XLEN'(2) << (XLEN - 4),
  parameter logic [XLEN-1:0] TGT_RST         = '0,
  parameter bit              DATA_MATCH_EN   = 1'b0,
  parameter bit              OPCODE_MATCH_EN = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic            csr_sel,
  input  logic            csr_dbg,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] ctrl_rdata,
  output logic [XLEN-1:0] tgt_rdata,
  input  logic            m_valid,
  input  logic [1:0]      m_kind,
  input  logic [1:0]      m_priv,
  input  logic            m_timing,
  input  logic            m_isdata,
  input  logic [XLEN-1:0] m_value,
  output logic            hit_o
);
  logic [XLEN-1:0] cmask, cmp_value, cmp_tgt;
  logic            clr_b0, cmp_match, kind_ok, priv_ok, hit_set;

  trig_regs #(
    .XLEN(XLEN), .CTRL_WMASK(CTRL_WMASK), .TGT_WMASK(TGT_WMASK),
    .CTRL_RST(CTRL_RST), .TGT_RST(TGT_RST),
    .DATA_MATCH_EN(DATA_MATCH_EN), .OPCODE_MATCH_EN(OPCODE_MATCH_EN)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_dbg(csr_dbg), .csr_wdata(csr_wdata), .hit_set(hit_set),
    .ctrl_q(ctrl_rdata), .tgt_q(tgt_rdata)
  );

  trig_cmask #(.XLEN(XLEN)) cmask_i (.tgt(tgt_rdata), .cmask(cmask));

  // Instruction addresses ignore bit 0 on both sides.
  assign clr_b0    = (op_kind_e'(m_kind) == OP_EXEC) && !ctrl_rdata[F_SELECT];
  assign cmp_value = clr_b0 ? (m_value & ~XLEN'(1)) : m_value;
  assign cmp_tgt   = clr_b0 ? (tgt_rdata & ~XLEN'(1)) : tgt_rdata;

  trig_compare #(.XLEN(XLEN)) cmp_i (
    .mode(ctrl_rdata[F_MATCH_LO +: F_MATCH_W]), .value(cmp_value),
    .tgt(cmp_tgt), .cmask(cmask), .match(cmp_match)
  );

  always_comb begin
    case (op_kind_e'(m_kind))
      OP_LOAD:  kind_ok = ctrl_rdata[F_LOAD];
      OP_STORE: kind_ok = ctrl_rdata[F_STORE];
      OP_EXEC:  kind_ok = ctrl_rdata[F_EXEC];
      default:  kind_ok = 1'b0;
    endcase
    case (priv_e'(m_priv))
      PRV_U:   priv_ok = ctrl_rdata[F_UMODE];
      PRV_S:   priv_ok = ctrl_rdata[F_SMODE];
      PRV_M:   priv_ok = ctrl_rdata[F_MMODE];
      default: priv_ok = 1'b0;
    endcase
  end

  assign hit_set = m_valid && kind_ok && priv_ok && cmp_match
                   && (m_timing == ctrl_rdata[F_TIMING])
                   && (m_isdata == ctrl_rdata[F_SELECT]);

  always_ff @(posedge clk) begin
    if (!rst_n) hit_o <= 1'b0;
    else        hit_o <= hit_set;
  end
endmodule

// File: rtl/dbg_match_trigger_chk.sv
module dbg_match_trigger_chk
  import dbg_trig_pkg::*;
#(
  parameter int unsigned XLEN            = 32,
  parameter bit          DATA_MATCH_EN   = 1'b0,
  parameter bit          OPCODE_MATCH_EN = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_we,
  input logic            csr_dbg,
  input logic            m_valid,
  input logic [XLEN-1:0] ctrl_rdata,
  input logic [XLEN-1:0] tgt_rdata,
  input logic            hit_o
);
  localparam int unsigned DM = dmode_pos(XLEN);

  // R2
  dmode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !csr_dbg && ctrl_rdata[DM] && !m_valid)
      |=> ($stable(ctrl_rdata) && $stable(tgt_rdata)));

  // R2
  dmode_nondebug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !csr_dbg) |=> $stable(ctrl_rdata[DM]));

  // R3
  action_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[DM] |-> (ctrl_rdata[F_ACT_LO +: F_ACT_W] == '0));

  // R7
  hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(ctrl_rdata[F_UMODE] || ctrl_rdata[F_SMODE] || ctrl_rdata[F_MMODE]));

  // R10
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(m_valid));

  // R10
  hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ctrl_rdata[F_HIT]);

  // R11
  data_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(csr_we) && ctrl_rdata[F_SELECT])
      |-> ((DATA_MATCH_EN || !ctrl_rdata[F_LOAD]) && (OPCODE_MATCH_EN || !ctrl_rdata[F_EXEC])));
endmodule

bind dbg_match_trigger dbg_match_trigger_chk #(
  .XLEN(XLEN), .DATA_MATCH_EN(DATA_MATCH_EN), .OPCODE_MATCH_EN(OPCODE_MATCH_EN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_dbg(csr_dbg),
  .m_valid(m_valid), .ctrl_rdata(ctrl_rdata), .tgt_rdata(tgt_rdata), .hit_o(hit_o)
);

// File: tb/dbg_match_trigger_tb.sv
module dbg_match_trigger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [31:0] TYPE_RO = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0, csr_sel = 1'b0, csr_dbg = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] ctrl_rdata, tgt_rdata;
  logic m_valid = 1'b0, m_timing = 1'b0, m_isdata = 1'b0;
  logic [1:0] m_kind = 2'd0, m_priv = 2'd3;
  logic [XLEN-1:0] m_value = '0;
  logic hit_o;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_match_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_dbg(csr_dbg), .csr_wdata(csr_wdata), .ctrl_rdata(ctrl_rdata),
    .tgt_rdata(tgt_rdata), .m_valid(m_valid), .m_kind(m_kind),
    .m_priv(m_priv), .m_timing(m_timing), .m_isdata(m_isdata),
    .m_value(m_value), .hit_o(hit_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit ld, bit st, bit ex, bit u, bit s, bit m,
                                     int mt, int act, bit tim, bit sel, bit dm);
    logic [31:0] v = '0;
    v[0] = ld; v[1] = st; v[2] = ex; v[3] = u; v[4] = s; v[6] = m;
    v[10:7] = 4'(mt); v[17:12] = 6'(act); v[18] = tim; v[19] = sel; v[27] = dm;
    return v;
  endfunction

  task automatic wr(bit sel, logic [31:0] d, bit dbg);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d; csr_dbg = dbg;
    @(negedge clk);
    csr_we = 1'b0; csr_dbg = 1'b0;
  endtask

  task automatic req(int kind, int priv, bit tim, bit isd, logic [31:0] v, output bit hit);
    @(negedge clk);
    m_valid = 1'b1; m_kind = 2'(kind); m_priv = 2'(priv);
    m_timing = tim; m_isdata = isd; m_value = v;
    @(negedge clk);
    hit = hit_o;
    m_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctrl reset", ctrl_rdata, TYPE_RO);
    check("R1 tgt reset", tgt_rdata, 32'h0);
    check("R1 hit reset", {31'b0, hit_o}, 32'h0);
  endtask

  task automatic t_write_rules();
    wr(1'b0, 32'hFFFF_FFFF, 1'b0);
    check("R2 R3 R8 R11 ctrl all-ones write", ctrl_rdata, 32'h201C_0FDA);
    wr(1'b0, 32'h0, 1'b0);
    check("R8 ctrl clear", ctrl_rdata, TYPE_RO);
  endtask

  task automatic t_exec_equal();
    bit h;
    wr(1'b0, mk(0,0,1,0,0,1,0,0,0,0,0), 1'b0);
    wr(1'b1, 32'h0000_1001, 1'b0);
    req(2, 3, 0, 0, 32'h0000_1000, h); check("R6 exec addr bit0 ignored", {31'b0,h}, 1);
    check("R10 hit bit set", {31'b0, ctrl_rdata[20]}, 1);
    @(negedge clk); check("R10 hit is one pulse", {31'b0, hit_o}, 0);
    req(2, 3, 0, 0, 32'h0000_1002, h); check("R5 equal mismatch", {31'b0,h}, 0);
    req(2, 0, 0, 0, 32'h0000_1000, h); check("R7 user not enabled", {31'b0,h}, 0);
    req(2, 2, 0, 0, 32'h0000_1000, h); check("R7 reserved priv", {31'b0,h}, 0);
    req(0, 3, 0, 0, 32'h0000_1000, h); check("R9 load kind off", {31'b0,h}, 0);
    req(2, 3, 1, 0, 32'h0000_1000, h); check("R9 timing mismatch", {31'b0,h}, 0);
    req(2, 3, 0, 1, 32'h0000_1000, h); check("R9 select mismatch", {31'b0,h}, 0);
    wr(1'b0, mk(0,0,1,0,0,0,0,0,0,0,0), 1'b0);
    check("R10 hit bit cleared by write", {31'b0, ctrl_rdata[20]}, 0);
    req(2, 3, 0, 0, 32'h0000_1000, h); check("R7 no priv enable", {31'b0,h}, 0);
  endtask

  task automatic t_masked();
    bit h;
    wr(1'b0, mk(0,1,0,1,0,0,1,0,0,0,0), 1'b0);
    wr(1'b1, 32'h0000_10FF, 1'b0);
    req(1, 0, 0, 0, 32'h0000_11FF, h); check("R4 masked low bits ignored", {31'b0,h}, 1);
    req(1, 0, 0, 0, 32'h0000_1200, h); check("R4 masked bit9 compared", {31'b0,h}, 0);
    req(0, 0, 0, 0, 32'h0000_11FF, h); check("R9 store-only vs load", {31'b0,h}, 0);
    wr(1'b1, 32'h7FFF_FFFF, 1'b0);
    req(1, 0, 0, 0, 32'hDEAD_BEEF, h); check("R4 zero mask matches all", {31'b0,h}, 1);
  endtask

  task automatic t_ordered();
    bit h;
    wr(1'b1, 32'h8000_0000, 1'b0);
    wr(1'b0, mk(1,0,0,0,1,0,2,0,1,0,0), 1'b0);
    req(0, 1, 1, 0, 32'h8000_0000, h); check("R5 ge equal", {31'b0,h}, 1);
    req(0, 1, 1, 0, 32'h7FFF_FFFF, h); check("R5 ge unsigned below", {31'b0,h}, 0);
    wr(1'b0, mk(1,0,0,0,1,0,3,0,1,0,0), 1'b0);
    req(0, 1, 1, 0, 32'h7FFF_FFFF, h); check("R5 lt below", {31'b0,h}, 1);
    req(0, 1, 1, 0, 32'hFFFF_FFFF, h); check("R5 lt unsigned above", {31'b0,h}, 0);
    wr(1'b0, mk(1,0,0,0,1,0,6,0,1,0,0), 1'b0);
    req(0, 1, 1, 0, 32'h8000_0000, h); check("R5 undefined mode", {31'b0,h}, 0);
  endtask

  task automatic t_halves();
    bit h;
    wr(1'b1, 32'h00FF_0034, 1'b0);
    wr(1'b0, mk(1,0,0,0,0,1,4,0,0,0,0), 1'b0);
    req(0, 3, 0, 0, 32'h0000_AB34, h); check("R5 mode4 match", {31'b0,h}, 1);
    req(0, 3, 0, 0, 32'h0000_AB35, h); check("R5 mode4 mismatch", {31'b0,h}, 0);
    wr(1'b1, 32'h0F0F_0005, 1'b0);
    wr(1'b0, mk(1,0,0,0,0,1,5,0,0,0,0), 1'b0);
    req(0, 3, 0, 0, 32'hF005_9999, h); check("R5 mode5 match", {31'b0,h}, 1);
    req(0, 3, 0, 0, 32'h1235_0005, h); check("R5 mode5 mismatch", {31'b0,h}, 0);
  endtask

  task automatic t_data_select();
    bit h;
    wr(1'b0, mk(1,1,1,0,0,1,0,0,0,1,0), 1'b0);
    check("R11 load/exec cleared", ctrl_rdata, mk(0,1,0,0,0,1,0,0,0,1,0) | TYPE_RO);
    wr(1'b1, 32'hCAFE_F00D, 1'b0);
    req(1, 3, 0, 1, 32'hCAFE_F00D, h); check("R9 store data match", {31'b0,h}, 1);
    req(1, 3, 0, 0, 32'hCAFE_F00D, h); check("R9 address vs data select", {31'b0,h}, 0);
  endtask

  task automatic t_dmode();
    logic [31:0] locked_v;
    locked_v = mk(0,0,1,0,0,1,0,1,0,0,1) | TYPE_RO;
    wr(1'b0, mk(0,0,1,0,0,1,0,1,0,0,1), 1'b1);
    check("R2 debug write sets dmode/action", ctrl_rdata, locked_v);
    wr(1'b1, 32'h0000_0100, 1'b1);
    wr(1'b0, 32'h0, 1'b0);
    check("R2 locked ctrl ignored", ctrl_rdata, locked_v);
    wr(1'b1, 32'h1234_5678, 1'b0);
    check("R2 locked tgt ignored", tgt_rdata, 32'h0000_0100);
    wr(1'b0, mk(0,0,1,0,0,1,0,1,0,0,0), 1'b1);
    check("R3 action cleared with dmode", ctrl_rdata, mk(0,0,1,0,0,1,0,0,0,0,0) | TYPE_RO);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_rules();
    t_exec_equal();
    t_masked();
    t_ordered();
    t_halves();
    t_data_select();
    t_dmode();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule